// File: doc/BRIEF.md
# Shadow-Bit Set-Associative Replacement Controller

This block holds the tag store and the replacement state of a small set-associative cache. It does not hold the cache data. Each line has a valid flag, a tag, a *special* flag and a *shadow* flag. Within each set the lines are kept in recency order, from position 0 (oldest) to position WAYS-1 (newest). Every line also remembers which physical way it occupies.

Accesses arrive with a valid/ready handshake and carry a line address (the byte offset is already removed). A second input, a one-bit hint, comes from an external predictor and says whether a missing line should be treated as a shadow line. One cycle after the block accepts an access, it reports:
- hit or miss;
- on a miss, the physical way that receives the new line.

Running counts of hits and misses are available as outputs.

Victims are chosen from the two status flags rather than from age stamps. A line without special status is replaced where it stands. Only when every line in the set is special does the set drop its oldest line and append the newcomer at the newest position.

Top module: `shadow_repl_ctrl`

## Requirements
- R1: Reset invalidates every line and clears its special and shadow flags. It zeroes both counters, drops rsp_valid and req_ready, and gives way w the recency position w. After reset, req_ready is 1, and the first miss in an empty set fills way 0.
- R2: For each accepted access (req_valid and req_ready high at a clock edge), rsp_valid is 1 in the following cycle. In that cycle exactly one of rsp_hit and rsp_miss is 1.
- R3: On a hit at position p, the hit line becomes the newest line (position WAYS-1). The lines at positions p+1 and above each move one position toward position 0.
- R4: On a hit, the line's special flag becomes equal to its shadow flag. The hint input is ignored on a hit.
- R5: On a miss, the incoming line's shadow flag and special flag both take the value of req_shadow_hint.
- R6: On a miss with an invalid line in the set, the invalid line at the lowest position is filled in place. rsp_victim reports that line's way.
- R7: On a miss with all lines valid and at least one non-special, the non-special line at the lowest position is replaced in place. rsp_victim reports its way.
- R8: On a miss with all lines valid and special, the line at position 0 is discarded. The others move one position toward 0, and the new line takes position WAYS-1 in the discarded line's way, which rsp_victim reports.
- R9: hit_count increases by one for each reported hit. miss_count increases by one for each reported miss.
- R10: The set index is req_addr[OFFSET_W +: log2(SETS)] and the tag is the bits above it. Accesses to one set leave every other set unchanged.
- R11: In a cycle with no accepted access, no line and neither counter changes, and rsp_valid is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block accepts an access this cycle |
| req_addr | input | ADDR_W | Line address, offset bits below OFFSET_W |
| req_shadow_hint | input | 1 | Predictor says the line is a shadow line |
| rsp_valid | output | 1 | Result of the previous accepted access |
| rsp_hit | output | 1 | Access hit |
| rsp_miss | output | 1 | Access missed |
| rsp_victim | output | log2(WAYS) | Way filled on a miss |
| hit_count | output | CNT_W | Running hit count |
| miss_count | output | CNT_W | Running miss count |

## Verification
Most state errors in this block stay hidden at first. A wrong recency order or a wrong special flag does not change the very next result. It appears only at a later miss in the same set, as an unexpected rsp_victim, or later still as a hit that should have been a miss (or the reverse).

The stimulus therefore fills a set and then mixes hits with both kinds of miss. Each ordering mistake surfaces within two or three accesses to that set. An inverted index/tag split shows at once, as a foreign hit or a victim in an untouched set. Counter mistakes show when the totals are compared at the end of the table.

// File: rtl/shadow_repl_pkg.sv
package shadow_repl_pkg;
  // Update applied to the addressed set
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_PROMOTE = 2'd1,  // hit: move line to newest position
    UPD_INPLACE = 2'd2,  // miss: overwrite a line where it stands
    UPD_APPEND  = 2'd3   // miss, set all special: drop oldest, append new
  } upd_e;
endpackage

// File: rtl/shadow_set_scan.sv
module shadow_set_scan #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 5,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0]            spc,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_pos,
  output logic                       all_special,
  output logic [WAY_W-1:0]           free_pos
);
  logic             has_inv, has_ns;
  logic [WAY_W-1:0] inv_pos, ns_pos;

  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (vld[i] && (tags[i] == look_tag)) begin
        hit     = 1'b1;
        hit_pos = WAY_W'(i);
      end
    end
  end

  // lowest position wins: scan from the top down
  always_comb begin
    has_inv = 1'b0;
    has_ns  = 1'b0;
    inv_pos = '0;
    ns_pos  = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        has_inv = 1'b1;
        inv_pos = WAY_W'(i);
      end
      if (vld[i] && !spc[i]) begin
        has_ns = 1'b1;
        ns_pos = WAY_W'(i);
      end
    end
    all_special = !has_inv && !has_ns;
    free_pos    = has_inv ? inv_pos : ns_pos;
  end
endmodule

// File: rtl/shadow_set_update.sv
module shadow_set_update
  import shadow_repl_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 5,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  upd_e                       op,
  input  logic [WAY_W-1:0]           pos,
  input  logic [TAG_W-1:0]           new_tag,
  input  logic                       new_shd,
  input  logic [WAYS-1:0]            vld_i,
  input  logic [WAYS-1:0]            spc_i,
  input  logic [WAYS-1:0]            shd_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tag_i,
  input  logic [WAYS-1:0][WAY_W-1:0] wid_i,
  output logic [WAYS-1:0]            vld_o,
  output logic [WAYS-1:0]            spc_o,
  output logic [WAYS-1:0]            shd_o,
  output logic [WAYS-1:0][TAG_W-1:0] tag_o,
  output logic [WAYS-1:0][WAY_W-1:0] wid_o
);
  always_comb begin
    vld_o = vld_i;
    spc_o = spc_i;
    shd_o = shd_i;
    tag_o = tag_i;
    wid_o = wid_i;
    case (op)
      UPD_INPLACE: begin
        vld_o[pos] = 1'b1;
        tag_o[pos] = new_tag;
        shd_o[pos] = new_shd;
        spc_o[pos] = new_shd;
      end
      UPD_PROMOTE, UPD_APPEND: begin
        for (int i = 0; i < WAYS - 1; i++) begin
          if (i >= int'(pos)) begin
            vld_o[i] = vld_i[i+1];
            spc_o[i] = spc_i[i+1];
            shd_o[i] = shd_i[i+1];
            tag_o[i] = tag_i[i+1];
            wid_o[i] = wid_i[i+1];
          end
        end
        vld_o[WAYS-1] = 1'b1;
        wid_o[WAYS-1] = wid_i[pos];
        if (op == UPD_PROMOTE) begin
          tag_o[WAYS-1] = tag_i[pos];
          shd_o[WAYS-1] = shd_i[pos];
          spc_o[WAYS-1] = shd_i[pos];
        end else begin
          tag_o[WAYS-1] = new_tag;
          shd_o[WAYS-1] = new_shd;
          spc_o[WAYS-1] = new_shd;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shadow_repl_ctrl.sv
module shadow_repl_ctrl
  import shadow_repl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OFFSET_W = 0,
  parameter int WAYS     = 4,
  parameter int SETS     = 8,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - IDX_W,
  localparam int WAY_W   = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_shadow_hint,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [WAY_W-1:0]  rsp_victim,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  // per-set state, index = recency position
  logic [WAYS-1:0]            vld_q [SETS];
  logic [WAYS-1:0]            spc_q [SETS];
  logic [WAYS-1:0]            shd_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  logic [WAYS-1:0][WAY_W-1:0] wid_q [SETS];

  logic                       rdy_q;
  logic                       acc;
  logic [IDX_W-1:0]           set_idx;
  logic [TAG_W-1:0]           acc_tag;
  logic                       lk_hit, lk_full;
  logic [WAY_W-1:0]           lk_hit_pos, lk_free_pos, upd_pos;
  upd_e                       upd_op;
  logic [WAYS-1:0]            n_vld, n_spc, n_shd;
  logic [WAYS-1:0][TAG_W-1:0] n_tag;
  logic [WAYS-1:0][WAY_W-1:0] n_wid;

  logic                       rsp_valid_d, rsp_hit_d, rsp_miss_d;
  logic [WAY_W-1:0]           rsp_victim_d;
  logic [CNT_W-1:0]           hit_count_d, miss_count_d;

  assign req_ready = rdy_q;
  assign acc       = req_valid && rdy_q;
  assign set_idx   = req_addr[OFFSET_W +: IDX_W];
  assign acc_tag   = req_addr[OFFSET_W + IDX_W +: TAG_W];

  shadow_set_scan #(.WAYS(WAYS), .TAG_W(TAG_W)) u_scan (
    .vld         (vld_q[set_idx]),
    .spc         (spc_q[set_idx]),
    .tags        (tag_q[set_idx]),
    .look_tag    (acc_tag),
    .hit         (lk_hit),
    .hit_pos     (lk_hit_pos),
    .all_special (lk_full),
    .free_pos    (lk_free_pos)
  );

  always_comb begin
    if (!acc) begin
      upd_op  = UPD_NONE;
      upd_pos = '0;
    end else if (lk_hit) begin
      upd_op  = UPD_PROMOTE;
      upd_pos = lk_hit_pos;
    end else if (lk_full) begin
      upd_op  = UPD_APPEND;
      upd_pos = '0;
    end else begin
      upd_op  = UPD_INPLACE;
      upd_pos = lk_free_pos;
    end
  end

  shadow_set_update #(.WAYS(WAYS), .TAG_W(TAG_W)) u_upd (
    .op      (upd_op),
    .pos     (upd_pos),
    .new_tag (acc_tag),
    .new_shd (req_shadow_hint),
    .vld_i   (vld_q[set_idx]),
    .spc_i   (spc_q[set_idx]),
    .shd_i   (shd_q[set_idx]),
    .tag_i   (tag_q[set_idx]),
    .wid_i   (wid_q[set_idx]),
    .vld_o   (n_vld),
    .spc_o   (n_spc),
    .shd_o   (n_shd),
    .tag_o   (n_tag),
    .wid_o   (n_wid)
  );

  // response and counter next state
  always_comb begin
    rsp_valid_d  = acc;
    rsp_hit_d    = acc && lk_hit;
    rsp_miss_d   = acc && !lk_hit;
    rsp_victim_d = wid_q[set_idx][upd_pos];
    hit_count_d  = hit_count  + CNT_W'(rsp_hit_d);
    miss_count_d = miss_count + CNT_W'(rsp_miss_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        spc_q[s] <= '0;
        shd_q[s] <= '0;
        tag_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) wid_q[s][w] <= WAY_W'(w);
      end
    end else if (acc) begin
      for (int s = 0; s < SETS; s++) begin
        if (set_idx == IDX_W'(s)) begin
          vld_q[s] <= n_vld;
          spc_q[s] <= n_spc;
          shd_q[s] <= n_shd;
          tag_q[s] <= n_tag;
          wid_q[s] <= n_wid;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_victim <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rdy_q      <= 1'b1;
      rsp_valid  <= rsp_valid_d;
      rsp_hit    <= rsp_hit_d;
      rsp_miss   <= rsp_miss_d;
      hit_count  <= hit_count_d;
      miss_count <= miss_count_d;
      if (acc) rsp_victim <= rsp_victim_d;
    end
  end
endmodule

// File: rtl/shadow_repl_chk.sv
module shadow_repl_chk #(
  parameter int WAY_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  // R2
  rsp_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R2
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1);

  // R9
  hit_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_hit == (hit_count != $past(hit_count))));

  // R9
  miss_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rsp_miss == (miss_count != $past(miss_count))));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!rsp_valid && $stable(hit_count) && $stable(miss_count)));
endmodule

bind shadow_repl_ctrl shadow_repl_chk #(.WAY_W(WAY_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_miss   (rsp_miss),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/sim_shadow_repl_ctrl.sv
module sim_shadow_repl_ctrl;
  localparam int CLK_P = 10;
  localparam int NV    = 19;

  // {addr[7:0], hint, expect_hit, expect_victim[1:0]}
  // set0 addr = tag<<3, set1 = tag<<3 | 1, set5 = tag<<3 | 5
  localparam logic [11:0] VEC [NV] = '{
    {8'h08, 1'b1, 1'b0, 2'd0},  // R6 fill way0
    {8'h10, 1'b1, 1'b0, 2'd1},  // R6
    {8'h18, 1'b0, 1'b0, 2'd2},  // R6, R5 non-special
    {8'h20, 1'b1, 1'b0, 2'd3},  // R6
    {8'h28, 1'b1, 1'b0, 2'd2},  // R7 in-place over non-special
    {8'h08, 1'b0, 1'b1, 2'd0},  // R3 hit, R4 hint ignored
    {8'h30, 1'b1, 1'b0, 2'd1},  // R8 front dropped
    {8'h10, 1'b0, 1'b0, 2'd2},  // R8 evicted tag misses
    {8'h38, 1'b1, 1'b0, 2'd2},  // R7 newest was non-special (R5)
    {8'h08, 1'b1, 1'b1, 2'd0},  // R3
    {8'h0D, 1'b1, 1'b0, 2'd0},  // R10 other set empty
    {8'h20, 1'b0, 1'b1, 2'd0},  // R3
    {8'h40, 1'b1, 1'b0, 2'd1},  // R8 order after promotions
    {8'h09, 1'b1, 1'b0, 2'd0},  // set1 fills
    {8'h11, 1'b1, 1'b0, 2'd1},
    {8'h19, 1'b0, 1'b0, 2'd2},
    {8'h21, 1'b1, 1'b0, 2'd3},
    {8'h19, 1'b1, 1'b1, 2'd0},  // R4 hit keeps special=shadow=0
    {8'h29, 1'b1, 1'b0, 2'd2}   // R4 still non-special victim
  };

  logic       clk, rst_n;
  logic       req_valid, req_ready, req_shadow_hint;
  logic [7:0] req_addr;
  logic       rsp_valid, rsp_hit, rsp_miss;
  logic [1:0] rsp_victim;
  logic [15:0] hit_count, miss_count;

  int checks = 0;
  int errors = 0;
  int exp_hits = 0;
  int exp_miss = 0;

  shadow_repl_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_shadow_hint(req_shadow_hint),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_victim(rsp_victim), .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input logic h);
    req_valid       = 1'b1;
    req_addr        = a;
    req_shadow_hint = h;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_shadow_hint = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(req_ready), 0);
    check("R1 hit_count", int'(hit_count), 0);
    check("R1 miss_count", int'(miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(req_ready), 1);
    check("R11 rsp idle", int'(rsp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][11:4], VEC[i][3]);
      check("R2 rsp_valid", int'(rsp_valid), 1);
      check("R2 hit", int'(rsp_hit), int'(VEC[i][2]));
      check("R2 miss", int'(rsp_miss), int'(!VEC[i][2]));
      if (VEC[i][2]) exp_hits++;
      else begin
        exp_miss++;
        check($sformatf("R6/R7/R8 victim vec%0d", i), int'(rsp_victim), int'(VEC[i][1:0]));
      end
    end
    check("R9 hit_count", int'(hit_count), exp_hits);
    check("R9 miss_count", int'(miss_count), exp_miss);

    // R11: idle cycles change nothing
    req_addr = 8'h08; req_shadow_hint = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 rsp_valid idle", int'(rsp_valid), 0);
    check("R11 hit_count stable", int'(hit_count), exp_hits);
    check("R11 miss_count stable", int'(miss_count), exp_miss);
    access(8'h08, 1'b0);   // still resident from table
    check("R11 line kept", int'(rsp_hit), 1);

    // R1: reset mid-run invalidates lines
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid reset", int'(rsp_valid), 0);
    check("R1 counters reset", int'(hit_count) + int'(miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    access(8'h08, 1'b1);
    check("R1 miss after reset", int'(rsp_miss), 1);
    check("R1 first fill way0", int'(rsp_victim), 0);
    check("R1 miss_count 1", int'(miss_count), 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule